// File: doc/BRIEF.md
# Branch and Conditional-Move Resolver

This block takes a stored set of arithmetic flags and a four-bit condition selector, and decides whether the condition holds. It applies that decision to one of three instruction kinds. For an unconditional jump it always redirects the program counter. For a conditional jump it redirects the program counter only when the condition holds. For a conditional move it grants a register-write enable.

The branch target is measured from the instruction that follows the branch. It equals the current address plus the instruction length plus the sign-extended displacement. When a branch is not taken, or when the instruction is not a branch, the next address is simply the current address plus the length.

Results are registered and appear one clock after a request is presented with `req_vld` high.

Top module: `brc_resolve`

## Requirements
- R1: Flag bits are packed {OV, NG, ZR, CY} from bit 3 down to bit 0. Selector codes evaluate as follows:
  - 0 = ZR
  - 1 = !ZR
  - 2 = NG
  - 3 = !NG
  - 4 = NG^OV
  - 5 = !(NG^OV)
  - 6 = (NG^OV)|ZR
  - 7 = !(NG^OV)&!ZR
  - 8 = CY
  - 9 = !CY
  - 10 = CY|ZR
  - 11 = !CY&!ZR
- R2: Selector codes 12 to 15 never evaluate true.
- R3: Kind 2'b00 (unconditional jump) is taken whatever the flags and selector. Its next address is pc + len + sign-extended disp.
- R4: Kind 2'b01 (conditional jump) is taken exactly when the selected condition holds. When taken, the next address is pc + len + sign-extended disp.
- R5: A conditional jump that is not taken gives next address pc + len.
- R6: Kind 2'b10 (conditional move) never reports taken, and its next address is pc + len. Its write enable equals the condition when the size field is 2'b01 (16-bit), 2'b10 (32-bit) or 2'b11 (64-bit).
- R7: A conditional move with size 2'b00 (byte) raises `size_err` and keeps the write enable low.
- R8: Outputs appear one cycle after `req_vld`. In a cycle with no request, `rsp_vld`, `taken`, `wr_en` and `size_err` are all low. Kind 2'b11 gives pc + len with all flags low.
- R9: While `rst` is high, every output is cleared to zero.
- R10: Next-address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 jump, 01 conditional jump, 10 conditional move, 11 none |
| req_size | input | 2 | Move size: 00 byte, 01 16, 10 32, 11 64 bits |
| req_cond | input | 4 | Condition selector |
| req_flags | input | 4 | {OV, NG, ZR, CY} |
| req_pc | input | ADDR_W | Address of the current instruction |
| req_len | input | LEN_W | Instruction length in bytes |
| req_disp | input | DISP_W | Signed branch displacement |
| rsp_vld | output | 1 | Result valid |
| next_pc | output | ADDR_W | Address of the next instruction to run |
| taken | output | 1 | Branch redirected |
| wr_en | output | 1 | Conditional-move destination write enable |
| size_err | output | 1 | Byte-size conditional move requested |

## Verification
The assertions assume that request fields are stable and meaningful only in cycles where `req_vld` is high. They also assume that each response follows its request by exactly one cycle with no back-pressure. The bench drives every field at the falling edge and raises `req_vld` only when a complete request is present. Once reset is released it holds reset low, so each one-cycle-back comparison sees a request taken outside reset.

// File: rtl/brc_resolve_pkg.sv
package brc_resolve_pkg;

    typedef struct packed {
        logic ov;
        logic ng;
        logic zr;
        logic cy;
    } flags_t;

    typedef enum logic [1:0] {
        K_JMP  = 2'b00,
        K_JCC  = 2'b01,
        K_CMOV = 2'b10,
        K_NONE = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'b00,
        SZ_16 = 2'b01,
        SZ_32 = 2'b10,
        SZ_64 = 2'b11
    } size_e;

    // Number of base condition pairs; each pair is (cond, !cond).
    localparam int unsigned NUM_PAIRS = 8;
    localparam int unsigned LIVE_PAIRS = 6;

    typedef struct packed {
        logic taken;
        logic wr_en;
        logic size_err;
    } ctrl_t;

    function automatic logic pair_live(input logic [2:0] idx);
        return idx < 3'(LIVE_PAIRS);
    endfunction

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_resolve_pkg::*;
(
    input  flags_t     flags,
    input  logic [3:0] sel,
    output logic       hit
);
    logic [brc_resolve_pkg::NUM_PAIRS-1:0] base;
    logic sgn_lt;
    logic uns_be;

    assign sgn_lt = flags.ng ^ flags.ov;
    assign uns_be = flags.cy | flags.zr;

    // Even code of each pair is the base condition; odd code inverts it.
    genvar g;
    generate
        for (g = 0; g < int'(brc_resolve_pkg::NUM_PAIRS); g++) begin : g_pair
            if (g == 0) begin : g_eq
                assign base[g] = flags.zr;
            end else if (g == 1) begin : g_neg
                assign base[g] = flags.ng;
            end else if (g == 2) begin : g_slt
                assign base[g] = sgn_lt;
            end else if (g == 3) begin : g_sle
                assign base[g] = sgn_lt | flags.zr;
            end else if (g == 4) begin : g_ult
                assign base[g] = flags.cy;
            end else if (g == 5) begin : g_ule
                assign base[g] = uns_be;
            end else begin : g_dead
                assign base[g] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        if (pair_live(sel[3:1])) begin
            hit = base[sel[3:1]] ^ sel[0];
        end
    end

    always_comb begin
        AST_DEAD_CODES: assert (!(sel[3:2] == 2'b11) || !hit); // R2
        AST_PAIR_SPLIT: assert (sel[3:2] == 2'b11 || (hit ^ sel[0]) == base[sel[3:1]]); // R1
    end

endmodule

// File: rtl/brc_target.sv
module brc_target #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 4,
    parameter int unsigned DISP_W = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [LEN_W-1:0]  len,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] fall_pc,
    output logic [ADDR_W-1:0] jump_pc
);
    localparam int unsigned LEN_PAD  = ADDR_W - LEN_W;
    localparam int unsigned DISP_PAD = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] len_ext;
    logic [ADDR_W-1:0] disp_ext;

    assign len_ext  = {{LEN_PAD{1'b0}}, len};
    assign disp_ext = {{DISP_PAD{disp[DISP_W-1]}}, disp};

    // Target is relative to the following instruction.
    assign fall_pc = pc + len_ext;
    assign jump_pc = fall_pc + disp_ext;

    always_comb begin
        AST_ZERO_DISP: assert (disp != '0 || jump_pc == fall_pc); // R4
    end

endmodule

// File: rtl/brc_ctrl.sv
module brc_ctrl
    import brc_resolve_pkg::*;
(
    input  logic [1:0] kind,
    input  logic [1:0] size,
    input  logic       hit,
    output ctrl_t      ctl
);
    kind_e k;
    size_e s;

    assign k = kind_e'(kind);
    assign s = size_e'(size);

    always_comb begin
        ctl = '0;
        unique case (k)
            K_JMP:  ctl.taken = 1'b1;
            K_JCC:  ctl.taken = hit;
            K_CMOV: begin
                if (s == SZ_8) begin
                    ctl.size_err = 1'b1;
                end else begin
                    ctl.wr_en = hit;
                end
            end
            default: ctl = '0;
        endcase
    end

    always_comb begin
        AST_ERR_BLOCKS_WR: assert (!ctl.size_err || !ctl.wr_en); // R7
        AST_ONE_ROLE:      assert (!(ctl.taken && (ctl.wr_en || ctl.size_err))); // R6
    end

endmodule

// File: rtl/brc_resolve.sv
module brc_resolve
    import brc_resolve_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 4,
    parameter int unsigned DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_size,
    input  logic [3:0]        req_cond,
    input  logic [3:0]        req_flags,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DISP_W-1:0] req_disp,
    output logic              rsp_vld,
    output logic [ADDR_W-1:0] next_pc,
    output logic              taken,
    output logic              wr_en,
    output logic              size_err
);
    logic              hit;
    logic [ADDR_W-1:0] fall_pc;
    logic [ADDR_W-1:0] jump_pc;
    ctrl_t             ctl;
    ctrl_t             ctl_q;

    brc_cond_eval u_eval (
        .flags (flags_t'(req_flags)),
        .sel   (req_cond),
        .hit   (hit)
    );

    brc_target #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DISP_W (DISP_W)
    ) u_tgt (
        .pc      (req_pc),
        .len     (req_len),
        .disp    (req_disp),
        .fall_pc (fall_pc),
        .jump_pc (jump_pc)
    );

    brc_ctrl u_ctl (
        .kind (req_kind),
        .size (req_size),
        .hit  (hit),
        .ctl  (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld <= 1'b0;
            next_pc <= '0;
            ctl_q   <= '0;
        end else begin
            rsp_vld <= req_vld;
            if (req_vld) begin
                ctl_q   <= ctl;
                next_pc <= ctl.taken ? jump_pc : fall_pc;
            end else begin
                ctl_q   <= '0;
            end
        end
    end

    assign taken    = ctl_q.taken;
    assign wr_en    = ctl_q.wr_en;
    assign size_err = ctl_q.size_err;

    AST_JMP_ALWAYS: assert property (@(posedge clk) disable iff (rst)
        req_vld && req_kind == 2'b00 |=> taken && next_pc == $past(jump_pc)); // R3
    AST_JCC_TARGET: assert property (@(posedge clk) disable iff (rst)
        req_vld && req_kind == 2'b01 |=> (taken ? next_pc == $past(jump_pc) : next_pc == $past(fall_pc))); // R4
    AST_JCC_DEAD: assert property (@(posedge clk) disable iff (rst)
        req_vld && req_kind == 2'b01 && req_cond[3:2] == 2'b11 |=> !taken); // R2
    AST_CMOV_STAYS: assert property (@(posedge clk) disable iff (rst)
        req_vld && req_kind == 2'b10 |=> !taken && next_pc == $past(fall_pc)); // R6
    AST_BYTE_MOVE: assert property (@(posedge clk) disable iff (rst)
        req_vld && req_kind == 2'b10 && req_size == 2'b00 |=> size_err && !wr_en); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !rsp_vld && !taken && !wr_en && !size_err); // R8
    AST_ONE_HOT_OUT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({taken, wr_en, size_err})); // R8

endmodule

// File: tb/brc_resolve_test.sv
module brc_resolve_test;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned LEN_W  = 4;
    localparam int unsigned DISP_W = 8;

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  size;
        logic [3:0]  cond;
        logic [3:0]  flags;
        logic [31:0] pc;
        logic [3:0]  len;
        logic [7:0]  disp;
        logic [31:0] exp_pc;
        logic        exp_tk;
        logic        exp_wr;
        logic        exp_er;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 2'b00, 4'd0,  4'b0000, 32'h0000_001a, 4'd2, 8'hed, 32'h0000_0009, 1'b1, 1'b0, 1'b0}, // R3 short back jump
        '{2'b01, 2'b00, 4'd0,  4'b0010, 32'h0000_0100, 4'd2, 8'h10, 32'h0000_0112, 1'b1, 1'b0, 1'b0}, // R4
        '{2'b01, 2'b00, 4'd0,  4'b0000, 32'h0000_0100, 4'd2, 8'h10, 32'h0000_0102, 1'b0, 1'b0, 1'b0}, // R5
        '{2'b01, 2'b00, 4'd4,  4'b0100, 32'h0000_2000, 4'd6, 8'h80, 32'h0000_1f86, 1'b1, 1'b0, 1'b0}, // R4 most negative disp
        '{2'b10, 2'b10, 4'd8,  4'b0001, 32'h0000_0400, 4'd3, 8'h22, 32'h0000_0403, 1'b0, 1'b1, 1'b0}, // R6 true move
        '{2'b10, 2'b11, 4'd8,  4'b0000, 32'h0000_0400, 4'd3, 8'h22, 32'h0000_0403, 1'b0, 1'b0, 1'b0}, // R6 false move
        '{2'b10, 2'b00, 4'd0,  4'b0010, 32'h0000_0400, 4'd3, 8'h22, 32'h0000_0403, 1'b0, 1'b0, 1'b1}, // R7 byte move
        '{2'b11, 2'b01, 4'd0,  4'b0010, 32'h0000_0500, 4'd5, 8'h7f, 32'h0000_0505, 1'b0, 1'b0, 1'b0}, // R8 kind none
        '{2'b00, 2'b00, 4'd3,  4'b0000, 32'hffff_fffe, 4'd2, 8'h05, 32'h0000_0005, 1'b1, 1'b0, 1'b0}, // R10 wrap
        '{2'b01, 2'b00, 4'd13, 4'b1111, 32'h0000_0600, 4'd2, 8'h40, 32'h0000_0602, 1'b0, 1'b0, 1'b0}, // R2
        '{2'b00, 2'b00, 4'd15, 4'b0000, 32'h0000_0700, 4'd1, 8'h01, 32'h0000_0702, 1'b1, 1'b0, 1'b0}  // R3 ignores dead code
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_vld = 1'b0;
    logic [1:0]        req_kind = '0;
    logic [1:0]        req_size = '0;
    logic [3:0]        req_cond = '0;
    logic [3:0]        req_flags = '0;
    logic [ADDR_W-1:0] req_pc = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [DISP_W-1:0] req_disp = '0;
    logic              rsp_vld;
    logic [ADDR_W-1:0] next_pc;
    logic              taken;
    logic              wr_en;
    logic              size_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    brc_resolve #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DISP_W(DISP_W)) uut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_kind(req_kind),
        .req_size(req_size), .req_cond(req_cond), .req_flags(req_flags),
        .req_pc(req_pc), .req_len(req_len), .req_disp(req_disp),
        .rsp_vld(rsp_vld), .next_pc(next_pc), .taken(taken),
        .wr_en(wr_en), .size_err(size_err)
    );

    function automatic logic model_cond(input logic [3:0] c, input logic [3:0] f);
        logic ov, ng, zr, cy;
        {ov, ng, zr, cy} = f;
        case (c)
            4'd0:  return zr;
            4'd1:  return !zr;
            4'd2:  return ng;
            4'd3:  return !ng;
            4'd4:  return ng ^ ov;
            4'd5:  return !(ng ^ ov);
            4'd6:  return (ng ^ ov) | zr;
            4'd7:  return !(ng ^ ov) & !zr;
            4'd8:  return cy;
            4'd9:  return !cy;
            4'd10: return cy | zr;
            4'd11: return !cy & !zr;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        req_vld   = 1'b1;
        req_kind  = v.kind;
        req_size  = v.size;
        req_cond  = v.cond;
        req_flags = v.flags;
        req_pc    = v.pc;
        req_len   = v.len;
        req_disp  = v.disp;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset clears outputs even with a request applied
        req_vld  = 1'b1;
        req_kind = 2'b00;
        req_pc   = 32'h1234;
        req_len  = 4'd2;
        repeat (3) @(negedge clk);
        check("R9 rsp_vld", 64'(rsp_vld), 64'd0);
        check("R9 next_pc", 64'(next_pc), 64'd0);
        check("R9 flags", 64'({taken, wr_en, size_err}), 64'd0);
        req_vld = 1'b0;
        rst = 1'b0;

        // R8: idle cycle gives quiet outputs
        @(negedge clk);
        @(negedge clk);
        check("R8 idle", 64'({rsp_vld, taken, wr_en, size_err}), 64'd0);

        // Table of directed vectors
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i]);
            check("R8 rsp_vld", 64'(rsp_vld), 64'd1);
            check("R3/R4/R5/R6/R10 next_pc", 64'(next_pc), 64'(VECS[i].exp_pc));
            check("R3/R4 taken", 64'(taken), 64'(VECS[i].exp_tk));
            check("R6 wr_en", 64'(wr_en), 64'(VECS[i].exp_wr));
            check("R7 size_err", 64'(size_err), 64'(VECS[i].exp_er));
        end

        // R1 / R2: every selector against every flag combination, branch form
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                vec_t v;
                logic e;
                e = model_cond(4'(c), 4'(f));
                v = '{2'b01, 2'b00, 4'(c), 4'(f), 32'h0000_1000, 4'd2, 8'h04,
                      e ? 32'h0000_1006 : 32'h0000_1002, e, 1'b0, 1'b0};
                drive(v);
                check(c < 12 ? "R1 taken" : "R2 taken", 64'(taken), 64'(e));
                check("R4/R5 next_pc", 64'(next_pc), 64'(v.exp_pc));
            end
        end

        // R6: selector drives move enable for a 16-bit move
        for (int f = 0; f < 16; f++) begin
            vec_t v;
            v = '{2'b10, 2'b01, 4'd7, 4'(f), 32'h0000_0800, 4'd4, 8'hff, 32'h0000_0804,
                  1'b0, model_cond(4'd7, 4'(f)), 1'b0};
            drive(v);
            check("R6 wr_en 16-bit", 64'(wr_en), 64'(v.exp_wr));
            check("R6 no taken", 64'(taken), 64'd0);
        end

        // R8: after the last request the outputs return low
        @(negedge clk);
        check("R8 idle after", 64'({rsp_vld, taken, wr_en, size_err}), 64'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule